// File: doc/BRIEF.md
# Integer Register-Operation Execute Unit

This block is the integer execute stage for register-class operations of a 32-bit load/store processor. Each cycle it takes an operation code, two register operands, a 16-bit immediate and a flag that picks the immediate in place of the second register. It returns a 32-bit result and a signed-overflow flag.

The operations are:
- add and subtract, in signed and unsigned flavours;
- bitwise AND, OR and XOR;
- logical left and right shifts, and an arithmetic right shift;
- load-high-immediate;
- six signed set-on-comparison operations, each producing 0 or 1.

The immediate is sign-extended or zero-extended according to the operation class. A parameter selects between a purely combinational path and a single output register. Decode from raw instruction words, the register file, multiply and divide are handled elsewhere.

The unit holds no sequencing state of its own. The only clocked storage is the optional output stage. That stage has two named conditions:
- `EMPTY`: `out_valid` low. It moves to `FULL` on a cycle with `in_valid` high.
- `FULL`: a result is presented. It stays `FULL` while `in_valid` stays high and returns to `EMPTY` on a cycle with `in_valid` low.

Reset forces `EMPTY`.

Top module: `exu_regops`

## Requirements
- R1: Op code 0 (signed add) and op code 2 (signed subtract) produce a + s and a - s modulo 2^32. The second operand s is `b` when `imm_sel` is 0, and the sign-extended immediate when `imm_sel` is 1.
- R2: For op codes 0 and 2, `ovf` is 1 exactly when the true signed result does not fit in 32 bits. For add, that means both operands have the same sign and the result sign differs. For subtract, it means the operand signs differ and the result sign differs from a.
- R3: Op code 1 (unsigned add) and op code 3 (unsigned subtract) compute a + s and a - s with the immediate zero-extended. Every op code other than 0 and 2 gives `ovf` = 0.
- R4: Op codes 4 (AND), 5 (OR) and 6 (XOR) combine a with `b`, or with the zero-extended immediate when `imm_sel` is 1.
- R5: Op code 7 (load-high-immediate) gives {imm, 16'h0000}, whatever the values of a, b and `imm_sel`.
- R6: Op code 8 (left logical) and op code 9 (right logical) shift a and fill the vacated bits with zeros. The shift amount is the low 5 bits of `b`, or of the immediate when `imm_sel` is 1, so the range is 0 to 31.
- R7: Op code 10 (right arithmetic) shifts a right by the same 5-bit amount and copies a[31] into every vacated bit.
- R8: Op codes 11 to 16 compare a with s as signed values, with the immediate sign-extended, and return 1 when the condition holds and 0 otherwise. The codes are:
  - 11: less than
  - 12: greater than
  - 13: less or equal
  - 14: greater or equal
  - 15: equal
  - 16: not equal
- R9: Op codes 17 to 31 give result 0 and `ovf` 0.
- R10: With REG_OUT=1, the result and `ovf` for an operation presented with `in_valid` high appear one clock later with `out_valid` high, and `out_valid` is low otherwise. With REG_OUT=0 they appear in the same cycle. An active-low reset clears `out_valid`, `result` and `ovf`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operation presented this cycle |
| op | input | 5 | Operation code (see requirements) |
| a | input | 32 | First register operand |
| b | input | 32 | Second register operand |
| imm | input | 16 | Immediate field |
| imm_sel | input | 1 | 1: use the extended immediate as second operand |
| out_valid | output | 1 | Result presented |
| result | output | 32 | Operation result |
| ovf | output | 1 | Signed add/subtract overflow |

## Verification
Add and subtract are driven at the signed limits, 0x7FFFFFFF plus one and 0x80000000 minus one. These vectors separate the signed codes, which must flag overflow, from the unsigned codes, which must not. Immediates with bit 15 set show whether each operation class picked sign or zero extension: 0xFFFF means -1 for arithmetic and comparisons but 65535 for logical and unsigned operations. Shift amounts of 0, 31 and 33 exercise the 5-bit masking, and a negative operand separates arithmetic from logical right shift. A long run of random operands over every op code, defined and undefined, compares each result with an independent model, including the equal-operand case for the comparisons.

// File: rtl/exu_pkg.sv
package exu_pkg;

    typedef enum logic [4:0] {
        OP_ADD  = 5'd0,
        OP_ADDU = 5'd1,
        OP_SUB  = 5'd2,
        OP_SUBU = 5'd3,
        OP_AND  = 5'd4,
        OP_OR   = 5'd5,
        OP_XOR  = 5'd6,
        OP_LHI  = 5'd7,
        OP_SLL  = 5'd8,
        OP_SRL  = 5'd9,
        OP_SRA  = 5'd10,
        OP_SLT  = 5'd11,
        OP_SGT  = 5'd12,
        OP_SLE  = 5'd13,
        OP_SGE  = 5'd14,
        OP_SEQ  = 5'd15,
        OP_SNE  = 5'd16
    } op_e;

    localparam int OP_W = 5;

    // operand extension style chosen per operation class
    typedef enum logic {
        EXT_ZERO = 1'b0,
        EXT_SIGN = 1'b1
    } ext_e;

    function automatic ext_e ext_for(input logic [OP_W-1:0] code);
        ext_e e;
        case (code)
            OP_ADD, OP_SUB, OP_SLT, OP_SGT,
            OP_SLE, OP_SGE, OP_SEQ, OP_SNE: e = EXT_SIGN;
            default:                        e = EXT_ZERO;
        endcase
        return e;
    endfunction

endpackage

// File: rtl/exu_operand_sel.sv
module exu_operand_sel
    import exu_pkg::*;
#(
    parameter int W     = 32,
    parameter int IMM_W = 16
) (
    input  logic [OP_W-1:0]  op,
    input  logic [W-1:0]     b,
    input  logic [IMM_W-1:0] imm,
    input  logic             imm_sel,
    output logic [W-1:0]     b_eff
);
    localparam int PAD = W - IMM_W;

    logic [W-1:0] imm_sx;
    logic [W-1:0] imm_zx;

    assign imm_sx = {{PAD{imm[IMM_W-1]}}, imm};
    assign imm_zx = {{PAD{1'b0}}, imm};

    always_comb begin
        if (!imm_sel) begin
            b_eff = b;
        end else if (ext_for(op) == EXT_SIGN) begin
            b_eff = imm_sx;
        end else begin
            b_eff = imm_zx;
        end
    end
endmodule

// File: rtl/exu_addsub.sv
module exu_addsub #(
    parameter int W = 32
) (
    input  logic [W-1:0] x,
    input  logic [W-1:0] y,
    input  logic         subtract,
    output logic [W-1:0] sum,
    output logic         sgn_ovf
);
    logic [W-1:0] y_inv;
    logic [W:0]   wide;

    assign y_inv = subtract ? ~y : y;
    assign wide  = {1'b0, x} + {1'b0, y_inv} + {{W{1'b0}}, subtract};
    assign sum   = wide[W-1:0];

    // operands (after inversion) agree in sign but the sum does not
    assign sgn_ovf = (x[W-1] == y_inv[W-1]) && (sum[W-1] != x[W-1]);
endmodule

// File: rtl/exu_shifter.sv
module exu_shifter #(
    parameter int W = 32
) (
    input  logic [W-1:0]         x,
    input  logic [$clog2(W)-1:0] amt,
    output logic [W-1:0]         shl,
    output logic [W-1:0]         shr_log,
    output logic [W-1:0]         shr_ari
);
    localparam int SW = $clog2(W);

    // logarithmic barrel, one stage per amount bit
    logic [W-1:0] l_st [SW+1];
    logic [W-1:0] r_st [SW+1];
    logic [W-1:0] s_st [SW+1];
    logic         fill;

    assign fill     = x[W-1];
    assign l_st[0]  = x;
    assign r_st[0]  = x;
    assign s_st[0]  = x;

    for (genvar k = 0; k < SW; k++) begin : g_stage
        localparam int D = 1 << k;
        assign l_st[k+1] = amt[k] ? {l_st[k][W-1-D:0], {D{1'b0}}} : l_st[k];
        assign r_st[k+1] = amt[k] ? {{D{1'b0}}, r_st[k][W-1:D]}   : r_st[k];
        assign s_st[k+1] = amt[k] ? {{D{fill}}, s_st[k][W-1:D]}   : s_st[k];
    end

    assign shl     = l_st[SW];
    assign shr_log = r_st[SW];
    assign shr_ari = s_st[SW];
endmodule

// File: rtl/exu_compare.sv
module exu_compare #(
    parameter int W = 32
) (
    input  logic [W-1:0] x,
    input  logic [W-1:0] y,
    output logic         lt,
    output logic         eq
);
    assign eq = (x == y);
    assign lt = $signed(x) < $signed(y);
endmodule

// File: rtl/exu_regops.sv
module exu_regops
    import exu_pkg::*;
#(
    parameter int W       = 32,
    parameter int IMM_W   = 16,
    parameter bit REG_OUT = 1'b1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic [4:0]       op,
    input  logic [W-1:0]     a,
    input  logic [W-1:0]     b,
    input  logic [IMM_W-1:0] imm,
    input  logic             imm_sel,
    output logic             out_valid,
    output logic [W-1:0]     result,
    output logic             ovf
);
    localparam int SW = $clog2(W);

    logic [W-1:0] b_eff;
    logic [W-1:0] as_sum;
    logic         as_ovf;
    logic         is_sub;
    logic [W-1:0] sh_l, sh_rl, sh_ra;
    logic         c_lt, c_eq;
    logic [W-1:0] nxt_res;
    logic         nxt_ovf;

    exu_operand_sel #(.W(W), .IMM_W(IMM_W)) u_opsel (
        .op(op), .b(b), .imm(imm), .imm_sel(imm_sel), .b_eff(b_eff)
    );

    assign is_sub = (op == OP_SUB) || (op == OP_SUBU);

    exu_addsub #(.W(W)) u_addsub (
        .x(a), .y(b_eff), .subtract(is_sub), .sum(as_sum), .sgn_ovf(as_ovf)
    );

    exu_shifter #(.W(W)) u_shift (
        .x(a), .amt(b_eff[SW-1:0]),
        .shl(sh_l), .shr_log(sh_rl), .shr_ari(sh_ra)
    );

    exu_compare #(.W(W)) u_cmp (
        .x(a), .y(b_eff), .lt(c_lt), .eq(c_eq)
    );

    // result selection
    always_comb begin
        nxt_res = '0;
        nxt_ovf = 1'b0;
        unique case (op)
            OP_ADD, OP_SUB: begin
                nxt_res = as_sum;
                nxt_ovf = as_ovf;
            end
            OP_ADDU, OP_SUBU: nxt_res = as_sum;
            OP_AND: nxt_res = a & b_eff;
            OP_OR:  nxt_res = a | b_eff;
            OP_XOR: nxt_res = a ^ b_eff;
            OP_LHI: nxt_res = {imm, {(W-IMM_W){1'b0}}};
            OP_SLL: nxt_res = sh_l;
            OP_SRL: nxt_res = sh_rl;
            OP_SRA: nxt_res = sh_ra;
            OP_SLT: nxt_res = {{(W-1){1'b0}}, c_lt};
            OP_SGT: nxt_res = {{(W-1){1'b0}}, !c_lt && !c_eq};
            OP_SLE: nxt_res = {{(W-1){1'b0}}, c_lt || c_eq};
            OP_SGE: nxt_res = {{(W-1){1'b0}}, !c_lt};
            OP_SEQ: nxt_res = {{(W-1){1'b0}}, c_eq};
            OP_SNE: nxt_res = {{(W-1){1'b0}}, !c_eq};
            default: begin
                nxt_res = '0;
                nxt_ovf = 1'b0;
            end
        endcase
    end

    // output stage: EMPTY / FULL
    typedef enum logic {
        ST_EMPTY = 1'b0,
        ST_FULL  = 1'b1
    } ost_e;

    if (REG_OUT) begin : g_reg
        ost_e         st_q;
        logic [W-1:0] res_q;
        logic         ovf_q;

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                st_q <= ST_EMPTY;
            end else begin
                unique case (st_q)
                    ST_EMPTY: st_q <= in_valid ? ST_FULL : ST_EMPTY;
                    ST_FULL:  st_q <= in_valid ? ST_FULL : ST_EMPTY;
                    default:  st_q <= ST_EMPTY;
                endcase
            end
        end

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                res_q <= '0;
                ovf_q <= 1'b0;
            end else if (in_valid) begin
                res_q <= nxt_res;
                ovf_q <= nxt_ovf;
            end
        end

        assign out_valid = (st_q == ST_FULL);
        assign result    = res_q;
        assign ovf       = ovf_q;
    end else begin : g_comb
        assign out_valid = in_valid && rst_n;
        assign result    = rst_n ? nxt_res : '0;
        assign ovf       = rst_n && nxt_ovf;
    end
endmodule

// File: rtl/exu_regops_chk.sv
module exu_regops_chk
    import exu_pkg::*;
#(
    parameter int W       = 32,
    parameter int IMM_W   = 16,
    parameter bit REG_OUT = 1'b1
) (
    input logic             clk,
    input logic             rst_n,
    input logic             in_valid,
    input logic [4:0]       op,
    input logic [W-1:0]     a,
    input logic [W-1:0]     b,
    input logic [IMM_W-1:0] imm,
    input logic             imm_sel,
    input logic             out_valid,
    input logic [W-1:0]     result,
    input logic             ovf
);
    // inputs aligned to the cycle the result is presented
    logic             k_valid;
    logic [4:0]       k_op;
    logic [W-1:0]     k_a;
    logic [W-1:0]     k_b;
    logic [IMM_W-1:0] k_imm;
    logic             k_sel;

    if (REG_OUT) begin : g_dly
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                k_valid <= 1'b0;
                k_op    <= '0;
                k_a     <= '0;
                k_b     <= '0;
                k_imm   <= '0;
                k_sel   <= 1'b0;
            end else begin
                k_valid <= in_valid;
                k_op    <= op;
                k_a     <= a;
                k_b     <= b;
                k_imm   <= imm;
                k_sel   <= imm_sel;
            end
        end
    end else begin : g_now
        assign k_valid = in_valid;
        assign k_op    = op;
        assign k_a     = a;
        assign k_b     = b;
        assign k_imm   = imm;
        assign k_sel   = imm_sel;
    end

    logic [W-1:0] k_s;
    assign k_s = k_sel ? {{(W-IMM_W){k_imm[IMM_W-1]}}, k_imm} : k_b;

    // R10: valid timing
    assert_valid_timing_R10: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid == k_valid);

    // R5: load-high-immediate
    assert_lhi_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (k_valid && k_op == OP_LHI) |-> result == {k_imm, {(W-IMM_W){1'b0}}});

    // R8: comparisons return 0 or 1
    assert_cmp_binary_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (k_valid && k_op >= OP_SLT && k_op <= OP_SNE) |-> result[W-1:1] == '0);

    // R8: equality
    assert_seq_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (k_valid && k_op == OP_SEQ) |-> result[0] == (k_a == k_s));

    // R3: no overflow outside signed add/subtract
    assert_no_overflow_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (k_valid && k_op != OP_ADD && k_op != OP_SUB) |-> !ovf);

    // R7: arithmetic right shift keeps the sign
    assert_sra_sign_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (k_valid && k_op == OP_SRA) |-> result[W-1] == k_a[W-1]);

    // R9: undefined codes
    assert_undef_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (k_valid && k_op > OP_SNE) |-> (result == '0 && !ovf));
endmodule

bind exu_regops exu_regops_chk #(.W(W), .IMM_W(IMM_W), .REG_OUT(REG_OUT)) u_chk (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op(op), .a(a), .b(b),
    .imm(imm), .imm_sel(imm_sel), .out_valid(out_valid), .result(result), .ovf(ovf)
);

// File: tb/exu_regops_test.sv
`timescale 1ns/1ps
module exu_regops_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [4:0]  op = '0;
    logic [31:0] a = '0;
    logic [31:0] b = '0;
    logic [15:0] imm = '0;
    logic        imm_sel = 1'b0;
    logic        out_valid;
    logic [31:0] result;
    logic        ovf;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    logic [31:0] q_res [$];
    logic        q_ovf [$];
    string       q_tag [$];

    always #4 clk = ~clk;   // 125 MHz

    exu_regops uut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op(op), .a(a), .b(b),
        .imm(imm), .imm_sel(imm_sel), .out_valid(out_valid), .result(result), .ovf(ovf)
    );

    // independent reference model
    function automatic void model(input logic [4:0] c, input logic [31:0] x,
                                  input logic [31:0] y, input logic [15:0] im,
                                  input logic sel, output logic [31:0] r,
                                  output logic v);
        logic signed [32:0] wide;
        logic signed [31:0] sx, sy_s;
        logic [31:0] y_s, y_z;
        int sh;
        y_s = sel ? {{16{im[15]}}, im} : y;
        y_z = sel ? {16'h0, im} : y;
        sx = x;
        sy_s = y_s;
        sh = int'(y_z[4:0]);
        r = 32'h0;
        v = 1'b0;
        case (c)
            5'd0: begin
                wide = 33'(sx) + 33'(sy_s);
                r = wide[31:0];
                v = (wide > 33'sd2147483647) || (wide < -33'sd2147483648);
            end
            5'd2: begin
                wide = 33'(sx) - 33'(sy_s);
                r = wide[31:0];
                v = (wide > 33'sd2147483647) || (wide < -33'sd2147483648);
            end
            5'd1: r = x + y_z;
            5'd3: r = x - y_z;
            5'd4: r = x & y_z;
            5'd5: r = x | y_z;
            5'd6: r = x ^ y_z;
            5'd7: r = {im, 16'h0};
            5'd8: r = x << sh;
            5'd9: r = x >> sh;
            5'd10: r = 32'(sx >>> sh);
            5'd11: r = {31'h0, sx <  sy_s};
            5'd12: r = {31'h0, sx >  sy_s};
            5'd13: r = {31'h0, sx <= sy_s};
            5'd14: r = {31'h0, sx >= sy_s};
            5'd15: r = {31'h0, sx == sy_s};
            5'd16: r = {31'h0, sx != sy_s};
            default: r = 32'h0;
        endcase
    endfunction

    task automatic drive(input logic [4:0] c, input logic [31:0] x, input logic [31:0] y,
                         input logic [15:0] im, input logic sel, input string tag);
        logic [31:0] er;
        logic ev;
        @(negedge clk);
        model(c, x, y, im, sel, er, ev);
        op = c; a = x; b = y; imm = im; imm_sel = sel; in_valid = 1'b1;
        q_res.push_back(er);
        q_ovf.push_back(ev);
        q_tag.push_back(tag);
    endtask

    task automatic pause();
        @(negedge clk);
        in_valid = 1'b0;
        a = $urandom; b = $urandom;
    endtask

    // monitor / scoreboard
    always @(posedge clk) begin
        #2;
        if (rst_n && !done && out_valid) begin
            checks++;
            if (q_res.size() == 0) begin
                errors++;
                $display("FAIL R10 unexpected out_valid, result %h expected none", result);
            end else begin
                logic [31:0] er;
                logic ev;
                string t;
                er = q_res.pop_front();
                ev = q_ovf.pop_front();
                t = q_tag.pop_front();
                if (result !== er || ovf !== ev) begin
                    errors++;
                    $display("FAIL %s op=%0d result %h ovf %b expected %h ovf %b",
                             t, uut.op, result, ovf, er, ev);
                end
            end
        end
    end

    initial begin
        #(8 * 200000);
        errors++;
        $display("FAIL watchdog expired actual hung expected finish");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        checks++;
        if (out_valid !== 1'b0 || result !== 32'h0 || ovf !== 1'b0) begin
            errors++;
            $display("FAIL R10 reset state %b/%h/%b expected 0/0/0", out_valid, result, ovf);
        end
        rst_n = 1'b1;
        @(negedge clk);
        checks++;
        if (out_valid !== 1'b0) begin
            errors++;
            $display("FAIL R10 idle out_valid %b expected 0", out_valid);
        end

        // R1 / R2: signed add and subtract
        drive(5'd0, 32'h7FFF_FFFF, 32'h1, 16'h0, 1'b0, "R2 add overflow");
        drive(5'd0, 32'h0000_0010, 32'h0, 16'hFFFF, 1'b1, "R1 addi sign ext");
        drive(5'd2, 32'h8000_0000, 32'h1, 16'h0, 1'b0, "R2 sub overflow");
        drive(5'd2, 32'h0000_0005, 32'h0, 16'h0007, 1'b1, "R1 subi");
        drive(5'd0, 32'h8000_0000, 32'h8000_0000, 16'h0, 1'b0, "R2 add neg overflow");
        // R3: unsigned
        drive(5'd1, 32'h7FFF_FFFF, 32'h1, 16'h0, 1'b0, "R3 addu no ovf");
        drive(5'd1, 32'h0000_0001, 32'h0, 16'hFFFF, 1'b1, "R3 addui zero ext");
        drive(5'd3, 32'h8000_0000, 32'h1, 16'h0, 1'b0, "R3 subu no ovf");
        drive(5'd3, 32'h0001_0000, 32'h0, 16'h8000, 1'b1, "R3 subui zero ext");
        // R4: logical
        drive(5'd5, 32'h0, 32'h0, 16'h8000, 1'b1, "R4 ori zero ext");
        drive(5'd4, 32'hFFFF_FFFF, 32'h0F0F_0F0F, 16'h0, 1'b0, "R4 and");
        drive(5'd6, 32'hFFFF_FFFF, 32'h0, 16'hFFFF, 1'b1, "R4 xori");
        pause();
        // R5: load high, operands ignored
        drive(5'd7, 32'hDEAD_BEEF, 32'h1234_5678, 16'h0042, 1'b0, "R5 lhi");
        drive(5'd7, 32'h0, 32'hFFFF_FFFF, 16'hABCD, 1'b1, "R5 lhi ignore");
        // R6 / R7: shifts
        drive(5'd8, 32'h0000_0001, 32'd33, 16'h0, 1'b0, "R6 sll masked");
        drive(5'd8, 32'h0000_0001, 32'd0, 16'd31, 1'b1, "R6 slli 31");
        drive(5'd9, 32'h8000_0000, 32'd31, 16'h0, 1'b0, "R6 srl");
        drive(5'd10, 32'h8000_0000, 32'd31, 16'h0, 1'b0, "R7 sra full");
        drive(5'd10, 32'hF000_0010, 32'h0, 16'h0002, 1'b1, "R7 srai");
        drive(5'd10, 32'h7000_0010, 32'd0, 16'h0, 1'b0, "R7 sra zero");
        // R8: comparisons
        drive(5'd11, 32'hFFFF_FFFF, 32'h1, 16'h0, 1'b0, "R8 slt signed");
        drive(5'd12, 32'h0, 32'h0, 16'hFFFF, 1'b1, "R8 sgti neg imm");
        drive(5'd13, 32'h5, 32'h5, 16'h0, 1'b0, "R8 sle equal");
        drive(5'd14, 32'h8000_0000, 32'h7FFF_FFFF, 16'h0, 1'b0, "R8 sge extremes");
        drive(5'd15, 32'hFFFF_FFFF, 32'h0, 16'hFFFF, 1'b1, "R8 seqi sign ext");
        drive(5'd16, 32'h7, 32'h0, 16'h0007, 1'b1, "R8 snei equal");
        // R9: undefined codes
        drive(5'd17, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 16'hFFFF, 1'b0, "R9 undef 17");
        drive(5'd31, 32'h7FFF_FFFF, 32'h1, 16'h1, 1'b1, "R9 undef 31");
        pause();
        pause();

        // random sweep across all codes
        for (int i = 0; i < 600; i++) begin
            logic [31:0] ra, rb;
            ra = $urandom;
            rb = (i % 5 == 0) ? ra : $urandom;
            drive(5'(i % 32), ra, rb, 16'($urandom), 1'($urandom), "R1-sweep");
            if (i % 7 == 0) pause();
        end
        pause();
        repeat (3) @(negedge clk);

        checks++;
        if (q_res.size() != 0) begin
            errors++;
            $display("FAIL R10 pending results %0d expected 0", q_res.size());
        end
        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule